// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer of a 12-bit successive-approximation converter. It watches active-low chip-select and write strobes, plus a sleep input. When it accepts a start it clears its state. It then samples, searches the code one bit at a time from the most significant bit down, and puts each trial code on a bus that feeds an external DAC. It reads a one-bit comparator result to decide each bit. At the end it copies the finished code into an output latch and pulls an active-low interrupt.

Strobes may be any width. The block stays cleared for as long as a start condition is present, and it begins converting only after the strobe is released. A new start that arrives mid-conversion throws that conversion away. If the interrupt is wired back to the write input with sleep low, the converter runs continuously. One external write pulse is needed after power-up to begin that loop. The strobes and sleep are asynchronous and pass through a two-flop synchronizer.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `intr_n` is 1, `result` is 0 and `dac_code` is 0.
- R2: The first bit-decision cycle presents `dac_code` = 0x800, with only the MSB set. Each decided bit is kept when `cmp_hi` is 1 and cleared when it is 0. The next lower bit is set as the new trial bit on that same clock.
- R3: With an ideal comparator (`cmp_hi` = input code >= `dac_code`), `result` equals the input code in straight binary. This holds at 0, at 0xFFF (full scale) and at codes in between.
- R4: Count rising edges from the release of the strobe. `result` holds the new code after the 19th edge. `intr_n` falls on the 20th edge: 2 synchronizer stages, 1 start-flop clear, 1 hold exit, and then 16 conversion cycles (2 sample, 12 bit, 1 transfer, 1 interrupt).
- R5: A start condition is present when the write strobe is low and either `cs_n` is low or `sleep` is low. While it lasts, however long, `dac_code` stays 0, `intr_n` stays 1 and no conversion completes.
- R6: `result` keeps its previous value throughout a conversion until the transfer cycle of that conversion.
- R7: A start condition that arrives during a conversion abandons that conversion. Timing then restarts from the new release, and the result comes only from the new conversion.
- R8: With `wr_n` driven by `intr_n` and `sleep` = 0, conversions repeat without further stimulus. `intr_n` falls every 24 clock cycles, and each result is correct.
- R9: A low write strobe with `cs_n` = 1 and `sleep` = 1 has no effect: `intr_n` and `result` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| wr_n | input | 1 | Active-low write/start strobe, asynchronous |
| sleep | input | 1 | When low, write alone forms a start condition |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above DAC level |
| dac_code | output | 12 | Trial code to the DAC |
| result | output | 12 | Latched conversion result |
| intr_n | output | 1 | Active-low end-of-conversion interrupt |

## Verification
Two functions can fall in the same cycle: a running bit search and the acceptance of a new start. The bench provokes this by pressing and releasing a strobe in the middle of the bit cycles, after changing the analog input. It judges the outcome by three things: the interrupt timing counted from the second release, the result matching the second input, and the old result staying in the latch until then. The free-running loop is a second source of overlap, because the interrupt that ends one conversion is itself the start of the next. There, the 24-cycle period and the per-conversion results are checked.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_SAMP,
        PH_BITS,
        PH_XFER,
        PH_IRQ
    } sar_phase_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = async_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '1;
                else        chain_q[s] <= chain_d[s];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_start.sv
module sar_start (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_n,
    input  logic wr_s_n,
    input  logic sleep_s,
    output logic start_o
);
    logic start_d, start_q;

    always_comb begin
        start_d = ~wr_s_n & (~cs_s_n | ~sleep_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_d;
    end

    assign start_o = start_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int W        = 12,
    parameter int SAMP_CYC = 2,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_hi,
    output logic [W-1:0]     dac_code,
    output logic [W-1:0]     result,
    output logic             intr_n,
    output sar_phase_e       phase_o,
    output logic [CNT_W-1:0] bit_o
);
    typedef struct packed {
        sar_phase_e       phase;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     code;
        logic [W-1:0]     res;
        logic             irq_n;
    } seq_state_t;

    localparam logic [W-1:0]     MSB_ONLY  = W'(1) << (W - 1);
    localparam logic [CNT_W-1:0] SAMP_LAST = CNT_W'(SAMP_CYC - 1);
    localparam logic [CNT_W-1:0] TOP_BIT   = CNT_W'(W - 1);

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = PH_HOLD;
            st_d.cnt   = '0;
            st_d.code  = '0;
            st_d.irq_n = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_HOLD: begin
                    st_d.phase = PH_SAMP;
                    st_d.cnt   = '0;
                end
                PH_SAMP: begin
                    if (st_q.cnt == SAMP_LAST) begin
                        st_d.phase = PH_BITS;
                        st_d.cnt   = TOP_BIT;
                        st_d.code  = MSB_ONLY;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                PH_BITS: begin
                    if (!cmp_hi) st_d.code[st_q.cnt] = 1'b0;
                    if (st_q.cnt == '0) begin
                        st_d.phase = PH_XFER;
                    end else begin
                        st_d.cnt                 = st_q.cnt - CNT_W'(1);
                        st_d.code[st_q.cnt - CNT_W'(1)] = 1'b1;
                    end
                end
                PH_XFER: begin
                    st_d.res   = st_q.code;
                    st_d.phase = PH_IRQ;
                end
                PH_IRQ: begin
                    st_d.irq_n = 1'b0;
                    st_d.phase = PH_IDLE;
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
            st_q.code  <= '0;
            st_q.res   <= '0;
            st_q.irq_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code = st_q.code;
    assign result   = st_q.res;
    assign intr_n   = st_q.irq_n;
    assign phase_o  = st_q.phase;
    assign bit_o    = st_q.cnt;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int W           = 12,
    parameter int SAMP_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic         sleep,
    input  logic         cmp_hi,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         intr_n
);
    localparam int CNT_W = $clog2((W > SAMP_CYC) ? W : SAMP_CYC);

    logic [2:0]       async_in, sync_out;
    logic             start_w;
    sar_phase_e       phase_w;
    logic [CNT_W-1:0] bit_w;

    assign async_in = {sleep, wr_n, cs_n};

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (async_in),
        .sync_o  (sync_out)
    );

    sar_start u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s_n  (sync_out[0]),
        .wr_s_n  (sync_out[1]),
        .sleep_s (sync_out[2]),
        .start_o (start_w)
    );

    sar_seq #(.W(W), .SAMP_CYC(SAMP_CYC), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_w),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .result   (result),
        .intr_n   (intr_n),
        .phase_o  (phase_w),
        .bit_o    (bit_w)
    );
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk
    import sar_pkg::*;
#(
    parameter int W     = 12,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_q,
    input sar_phase_e       phase_q,
    input logic [CNT_W-1:0] bit_q,
    input logic [W-1:0]     dac_code,
    input logic [W-1:0]     result,
    input logic             intr_n
);
    logic [W-1:0] below_mask;
    assign below_mask = (W'(1) << bit_q) - W'(1);

    // R5: an accepted start clears the trial code and releases the interrupt
    p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> (dac_code == '0 && intr_n));

    // R7: a start in any phase returns the sequencer to hold
    p_abort_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |=> (phase_q == PH_HOLD));

    // R2: the bit search opens with the MSB alone
    p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BITS && $past(phase_q) == PH_SAMP) |-> dac_code == (W'(1) << (W - 1)));

    // R2: the bit under test is always set in the trial code
    p_trial_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BITS) |-> dac_code[bit_q]);

    // R3: bits below the trial bit are still clear
    p_low_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_BITS) |-> ((dac_code & below_mask) == '0));

    // R6: the latch changes only out of the transfer cycle
    p_latch_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $past(phase_q) == PH_XFER);

    // R4: the interrupt falls only out of the interrupt cycle
    p_irq_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n) |-> $past(phase_q) == PH_IRQ);
endmodule

bind sar_conv_ctrl sar_conv_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_q  (start_w),
    .phase_q  (phase_w),
    .bit_q    (bit_w),
    .dac_code (dac_code),
    .result   (result),
    .intr_n   (intr_n)
);

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_b = 1'b1;
    logic        sleep = 1'b1;
    logic        loop_en = 1'b0;
    logic [11:0] vin = '0;
    logic        wr_n, cmp_hi, intr_n;
    logic [11:0] dac_code, result;
    int          checks = 0;
    int          failures = 0;

    always #4 clk = ~clk;

    assign wr_n   = loop_en ? intr_n : wr_b;
    assign cmp_hi = (vin >= dac_code);

    sar_conv_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .sleep    (sleep),
        .cmp_hi   (cmp_hi),
        .dac_code (dac_code),
        .result   (result),
        .intr_n   (intr_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Release the strobes and follow the conversion edge by edge.
    task automatic release_and_track(input logic [11:0] v, input logic [11:0] old_res);
        cs_n = 1'b1;
        wr_b = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            step();
            if (k == 5) check(dac_code == 12'h000, "R2 code before bits", dac_code, 0);
            if (k == 6) check(dac_code == 12'h800, "R2 MSB trial", dac_code, 12'h800);
            if (k == 7) check(dac_code == ((v >= 12'h800 ? 12'h800 : 12'h000) | 12'h400),
                              "R2 MSB decision", dac_code,
                              (v >= 12'h800 ? 12'h800 : 12'h000) | 12'h400);
            if (k == 18) check(result == old_res, "R6 latch held mid-run", result, old_res);
            if (k == 19) begin
                check(result == v, "R3 result code", result, v);
                check(intr_n == 1'b1, "R4 intr still high at edge 19", intr_n, 1);
            end
            if (k == 20) check(intr_n == 1'b0, "R4 intr low at edge 20", intr_n, 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check(intr_n == 1'b1, "R1 intr_n reset", intr_n, 1);
        check(result == 12'h000, "R1 result reset", result, 0);
        check(dac_code == 12'h000, "R1 dac reset", dac_code, 0);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_convert(input logic [11:0] v);
        logic [11:0] old_res;
        old_res = result;
        vin  = v;
        cs_n = 1'b0;
        wr_b = 1'b0;
        step();
        release_and_track(v, old_res);
        repeat (3) step();
    endtask

    task automatic t_wide_strobe();
        logic [11:0] old_res;
        old_res = result;
        vin  = 12'h5A3;
        cs_n = 1'b0;
        wr_b = 1'b0;
        repeat (5) step();
        for (int k = 0; k < 40; k++) begin
            step();
            if (k == 39) begin
                check(dac_code == 12'h000, "R5 dac held clear", dac_code, 0);
                check(intr_n == 1'b1, "R5 intr held high", intr_n, 1);
                check(result == old_res, "R5 no completion while held", result, old_res);
            end
        end
        release_and_track(12'h5A3, old_res);
        repeat (3) step();
    endtask

    task automatic t_sleep_start();
        logic [11:0] old_res;
        old_res = result;
        vin   = 12'h3C7;
        sleep = 1'b0;
        wr_b  = 1'b0;
        repeat (25) step();
        check(intr_n == 1'b1 && dac_code == 12'h000, "R5 write+sleep low holds", intr_n, 1);
        release_and_track(12'h3C7, old_res);
        sleep = 1'b1;
        repeat (3) step();
    endtask

    task automatic t_ignored();
        logic [11:0] old_res;
        old_res = result;
        vin  = 12'h111;
        wr_b = 1'b0;
        repeat (10) step();
        wr_b = 1'b1;
        repeat (30) step();
        check(intr_n == 1'b0, "R9 intr unchanged", intr_n, 0);
        check(result == old_res, "R9 result unchanged", result, old_res);
    endtask

    task automatic t_abort();
        logic [11:0] old_res;
        old_res = result;
        vin  = 12'h0F0;
        cs_n = 1'b0;
        wr_b = 1'b0;
        step();
        cs_n = 1'b1;
        wr_b = 1'b1;
        repeat (10) step();
        vin  = 12'hE1B;
        cs_n = 1'b0;
        wr_b = 1'b0;
        repeat (2) step();
        release_and_track(12'hE1B, old_res);
        repeat (3) step();
    endtask

    task automatic t_free_run();
        int gap;
        int falls;
        logic prev;
        vin   = 12'h7E5;
        sleep = 1'b0;
        cs_n  = 1'b1;
        wr_b  = 1'b1;
        loop_en = 1'b1;
        falls = 0;
        gap = 0;
        prev = intr_n;
        for (int k = 0; k < 120 && falls < 4; k++) begin
            step();
            gap++;
            if (prev && !intr_n) begin
                falls++;
                if (falls > 1) check(gap == 24, "R8 loop period", gap, 24);
                check(result == vin, "R8 loop result", result, vin);
                gap = 0;
                vin = vin + 12'h123;
            end
            prev = intr_n;
        end
        check(falls == 4, "R8 loop kept running", falls, 4);
        loop_en = 1'b0;
        sleep = 1'b1;
        repeat (30) step();
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_convert(12'hA37);
        t_convert(12'h000);
        t_convert(12'hFFF);
        t_convert(12'h801);
        t_convert(12'h7FF);
        t_wide_strobe();
        t_sleep_start();
        t_ignored();
        t_abort();
        t_free_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule